// File: doc/BRIEF.md
# Bipolar Pulse-Rate Line Encoder

This block turns a serial bit stream into two drive signals for a transformer-coupled line pair: a positive-pulse leg and a negative-pulse leg. Each bit occupies one cell. A cell begins only when the transmit clock selector strobes the bit enable, and the bit is captured on that same strobe. A zero puts two pulses into its cell and a one puts a single pulse into it, so the pulse rate carries the data. Every pulse takes the opposite polarity to the one before it, whether or not a cell boundary or an idle gap lies between them. This keeps the line free of DC.

The block runs on a 3.584 MHz system clock. A static rate input picks the cell length: 56 ticks for the 64 kbps line rate, or 64 ticks for the 56 kbps rate. A pulse lasts one quarter of the cell. The first pulse of a cell starts in the first tick of the cell. For a zero, the second pulse starts at mid-cell. Level setting, analog drive and octet framing belong to other blocks.

Top module: `ami_rate_encoder`

## Requirements
- R1: After reset both legs are low, and the first pulse sent after reset is on the positive leg.
- R2: A zero bit produces two pulses of Q ticks, where Q is one quarter of the cell length. The first starts at tick 0 of the cell. The second starts at tick 2Q. Tick 0 is the first clock after the edge that samples the bit enable.
- R3: A one bit produces a single pulse of Q ticks starting at tick 0, and the legs stay low for the rest of the cell.
- R4: Successive pulses alternate polarity, both within a cell and across cell boundaries.
- R5: With rate_sel = 0 a cell lasts 56 ticks and Q = 14. With rate_sel = 1 a cell lasts 64 ticks and Q = 16. The rate is captured at the start of each cell.
- R6: line_pos and line_neg are never high in the same cycle, and both are low outside a pulse.
- R7: data_in is sampled only on the clock edge where bit_en is high. Changes to data_in at any other time have no effect on the legs.
- R8: The polarity state is kept through idle periods. The first pulse after an idle gap is the opposite polarity of the last pulse before the gap.
- R9: A cell starts only on bit_en. If no further enable arrives, the legs stay low once the cell ends. An enable that arrives in the middle of a cell abandons that cell and starts a new one at tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.584 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| rate_sel | input | 1 | Line rate select: 0 = 64 kbps (56-tick cell), 1 = 56 kbps (64-tick cell) |
| bit_en | input | 1 | Single-cycle strobe that starts a cell and samples data_in |
| data_in | input | 1 | Bit to encode |
| line_pos | output | 1 | Positive-pulse drive leg |
| line_neg | output | 1 | Negative-pulse drive leg |

## Verification
The checker takes three things for granted. The bit enable is held low until the two-stage reset release has completed. The enable is a one-cycle strobe. No pulse on either leg can appear more than one slow cell after the last enable. The stimulus meets these conditions. The bench raises bit_en only at least five cycles after reset has been deasserted, drives it for exactly one cycle at a time, and changes rate_sel and data_in only on the falling clock edge. Inside its checks the bench varies data_in every tick, and it also uses long idle gaps and enables that cut a cell short, so that any polarity memory and any enable-driven restart are tested directly.

// File: rtl/ami_enc_pkg.sv
package ami_enc_pkg;

  // Default cell lengths in system clock ticks (3.584 MHz clock).
  localparam int DEF_TICKS_FAST = 56;   // 64 kbps line rate
  localparam int DEF_TICKS_SLOW = 64;   // 56 kbps line rate

  typedef enum logic {
    RATE_64K = 1'b0,
    RATE_56K = 1'b1
  } rate_e;

  // Leg index used by the output stage.
  typedef enum int {
    LEG_POS = 0,
    LEG_NEG = 1
  } leg_e;

endpackage

// File: rtl/ami_rst_sync.sv
module ami_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/ami_cell_timer.sv
module ami_cell_timer
  import ami_enc_pkg::*;
#(
  parameter int TICKS_FAST = DEF_TICKS_FAST,
  parameter int TICKS_SLOW = DEF_TICKS_SLOW,
  parameter int CNT_W      = $clog2(TICKS_SLOW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rate_sel,
  input  logic             data_in,
  output logic [CNT_W-1:0] tick,
  output logic [CNT_W-1:0] quarter,
  output logic             active,
  output logic             bit_q
);

  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(TICKS_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(TICKS_SLOW - 1);
  localparam logic [CNT_W-1:0] QTR_FAST  = CNT_W'(TICKS_FAST / 4);
  localparam logic [CNT_W-1:0] QTR_SLOW  = CNT_W'(TICKS_SLOW / 4);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] tick_q, tick_d;
  logic             active_q, active_d;
  rate_e            rate_q, rate_d;
  logic             bit_d, bit_r;
  logic [CNT_W-1:0] last_tick;

  assign last_tick = (rate_q == RATE_56K) ? LAST_SLOW : LAST_FAST;

  always_comb begin
    tick_d   = tick_q;
    active_d = active_q;
    rate_d   = rate_q;
    bit_d    = bit_r;
    if (bit_en) begin
      tick_d   = '0;
      active_d = 1'b1;
      rate_d   = rate_e'(rate_sel);
      bit_d    = data_in;
    end else if (active_q) begin
      if (tick_q == last_tick) begin
        active_d = 1'b0;
      end else begin
        tick_d = tick_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      active_q <= 1'b0;
      rate_q   <= RATE_64K;
      bit_r    <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      active_q <= active_d;
      rate_q   <= rate_d;
      bit_r    <= bit_d;
    end
  end

  assign tick    = tick_q;
  assign active  = active_q;
  assign bit_q   = bit_r;
  assign quarter = (rate_q == RATE_56K) ? QTR_SLOW : QTR_FAST;

endmodule

// File: rtl/ami_pulse_gen.sv
module ami_pulse_gen #(
  parameter int CNT_W = 6
) (
  input  logic             active,
  input  logic             bit_q,
  input  logic             bit_en,
  input  logic [CNT_W-1:0] tick,
  input  logic [CNT_W-1:0] quarter,
  output logic             pulse_on,
  output logic             pulse_next
);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] three_q;
  logic             first_win;
  logic             second_win;
  logic             mid_edge;

  always_comb begin
    half       = quarter << 1;
    three_q    = half + quarter;
    first_win  = tick < quarter;
    second_win = !bit_q && (tick >= half) && (tick < three_q);
    pulse_on   = active && (first_win || second_win);
    // The second pulse of a zero begins on the next tick.
    mid_edge   = active && !bit_q && (tick == (half - CNT_W'(1)));
    pulse_next = bit_en || mid_edge;
  end

endmodule

// File: rtl/ami_polarity_drv.sv
module ami_polarity_drv
  import ami_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_next,
  input  logic pulse_on,
  output logic line_pos,
  output logic line_neg
);

  // pol_q holds the polarity of the most recent pulse (1 = positive).
  logic       pol_q, pol_d;
  logic [1:0] leg;

  always_comb begin
    pol_d = pol_q;
    if (pulse_next) begin
      pol_d = !pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
    end else begin
      pol_q <= pol_d;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_leg
    assign leg[i] = pulse_on && (pol_q == (i == int'(LEG_POS)));
  end

  assign line_pos = leg[LEG_POS];
  assign line_neg = leg[LEG_NEG];

endmodule

// File: rtl/ami_rate_encoder.sv
module ami_rate_encoder
  import ami_enc_pkg::*;
#(
  parameter int TICKS_FAST = DEF_TICKS_FAST,
  parameter int TICKS_SLOW = DEF_TICKS_SLOW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel,
  input  logic bit_en,
  input  logic data_in,
  output logic line_pos,
  output logic line_neg
);

  localparam int CNT_W = $clog2(TICKS_SLOW);

  logic             rst_sync_n;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] quarter;
  logic             active;
  logic             bit_q;
  logic             pulse_on;
  logic             pulse_next;
  logic             en_gated;

  ami_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign en_gated = bit_en && rst_sync_n;

  ami_cell_timer #(
    .TICKS_FAST (TICKS_FAST),
    .TICKS_SLOW (TICKS_SLOW),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (en_gated),
    .rate_sel (rate_sel),
    .data_in  (data_in),
    .tick     (tick),
    .quarter  (quarter),
    .active   (active),
    .bit_q    (bit_q)
  );

  ami_pulse_gen #(
    .CNT_W (CNT_W)
  ) u_pulse (
    .active     (active),
    .bit_q      (bit_q),
    .bit_en     (en_gated),
    .tick       (tick),
    .quarter    (quarter),
    .pulse_on   (pulse_on),
    .pulse_next (pulse_next)
  );

  ami_polarity_drv u_pol (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pulse_next (pulse_next),
    .pulse_on   (pulse_on),
    .line_pos   (line_pos),
    .line_neg   (line_neg)
  );

endmodule

// File: rtl/ami_rate_encoder_chk.sv
module ami_rate_encoder_chk #(
  parameter int TICKS_SLOW = 64
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic line_pos,
  input logic line_neg
);

  localparam int SW = $clog2(TICKS_SLOW) + 1;
  localparam logic [SW-1:0] SAT = SW'(TICKS_SLOW);

  logic          last_pos_q;
  logic          seen_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
      since_q    <= SAT;
    end else begin
      if (line_pos) last_pos_q <= 1'b1;
      if (line_neg) last_pos_q <= 1'b0;
      if (line_pos || line_neg) seen_q <= 1'b1;
      if (bit_en) since_q <= '0;
      else if (since_q != SAT) since_q <= since_q + SW'(1);
    end
  end

  AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg)); // R6

  AST_FIRST_PULSE_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !line_neg); // R1

  AST_POS_AFTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos && !$past(line_pos)) |-> !last_pos_q); // R4

  AST_NEG_AFTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_neg && !$past(line_neg)) |-> last_pos_q); // R4

  AST_ENABLE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (line_pos || line_neg)); // R2

  AST_QUIET_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == SAT) |-> !(line_pos || line_neg)); // R9

endmodule

bind ami_rate_encoder ami_rate_encoder_chk #(
  .TICKS_SLOW (TICKS_SLOW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .line_pos (line_pos),
  .line_neg (line_neg)
);

// File: tb/ami_rate_encoder_tb.sv
module ami_rate_encoder_tb_top;

  localparam int CLK_PERIOD = 280;

  logic clk = 1'b0;
  logic rst_n;
  logic rate_sel;
  logic bit_en;
  logic data_in;
  logic line_pos;
  logic line_neg;

  int n_chk = 0;
  int n_err = 0;
  logic cur_pos = 1'b0;  // polarity of the last pulse expected (1 = positive)

  always #(CLK_PERIOD / 2) clk = ~clk;

  ami_rate_encoder dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .bit_en   (bit_en),
    .data_in  (data_in),
    .line_pos (line_pos),
    .line_neg (line_neg)
  );

  task automatic check(string req, logic exp_p, logic exp_n);
    n_chk++;
    if (line_pos !== exp_p || line_neg !== exp_n) begin
      n_err++;
      $display("FAIL %s: pos/neg actual=%b%b expected=%b%b at %0t",
               req, line_pos, line_neg, exp_p, exp_n, $time);
    end
    n_chk++;
    if (line_pos === 1'b1 && line_neg === 1'b1) begin
      n_err++;
      $display("FAIL R6: both legs high actual=11 expected=not 11 at %0t", $time);
    end
  endtask

  // Caller is at a falling edge. Starts a cell with bit d, then observes len ticks.
  task automatic run_cell(logic d, logic rate, int len, string tag);
    int t_cell;
    int q;
    logic on;
    t_cell = rate ? 64 : 56;   // R5
    q      = t_cell / 4;
    rate_sel = rate;
    data_in  = d;
    bit_en   = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      bit_en  = 1'b0;
      data_in = k[0] ^ ~d;     // R7: data moves between enables
      if (k == 0 || (!d && k == 2 * q && k < t_cell)) cur_pos = !cur_pos;
      on = (k < t_cell) && ((k < q) || (!d && k >= 2 * q && k < 3 * q));
      check((k >= t_cell) ? "R9" : tag, on && cur_pos, on && !cur_pos);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    rate_sel = 1'b0;
    bit_en   = 1'b0;
    data_in  = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R1", 1'b0, 1'b0);
    end

    // R1: first pulse after reset is positive
    run_cell(1'b1, 1'b0, 56, "R1/R3/R4");

    // R2 R3 R4 R5 R7: every 4-bit pattern at both rates, back-to-back cells
    for (int r = 0; r < 2; r++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int b = 3; b >= 0; b--) begin
          if (pat[b]) run_cell(1'b1, r[0], r ? 64 : 56, "R3/R4/R5/R7");
          else        run_cell(1'b0, r[0], r ? 64 : 56, "R2/R4/R5/R7");
        end
      end
    end

    // R8: idle gaps, polarity carried through
    run_cell(1'b0, 1'b0, 56 + 40, "R8");
    run_cell(1'b1, 1'b0, 56, "R8/R4");
    run_cell(1'b1, 1'b1, 64 + 30, "R8");
    run_cell(1'b1, 1'b1, 64, "R8/R4");
    run_cell(1'b1, 1'b0, 56 + 25, "R8");
    run_cell(1'b0, 1'b1, 64, "R8/R4/R5");

    // R9: enables that cut a cell short restart at tick 0
    run_cell(1'b0, 1'b1, 2 * 16 + 3, "R9/R4");
    run_cell(1'b0, 1'b0, 20, "R9/R4");
    run_cell(1'b1, 1'b0, 5, "R9/R4");
    run_cell(1'b0, 1'b0, 56 + 10, "R9/R2");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule